// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker turns a 64-bit virtual address into a physical address. It walks a four-level radix page table stored in memory. A walk begins with a one-cycle `start` pulse. That cycle samples the virtual address, the table root base and the access kind (write, user mode, instruction fetch). The walker then issues one 8-byte entry read per level over a valid/ready request channel and waits for the matching response beat. Each entry gives the base of the next table. At the last level, the entry gives the base of the page frame.

The walk stops as soon as an entry is found not present. When all four entries are present, the walker combines the permission bits of all four levels and compares them with the access kind. The result comes back with a one-cycle `done` pulse. It is either a physical address or a fault, with a 2-bit cause and the level that caused it. Only one walk is in flight at a time.

Top module: `ptWalker`

## Requirements
- R1: While `rstN` is low, `memReqValid` and `done` are low, and they stay low in the first cycle after reset.
- R2: The entry read at level L (0 = top, 3 = last) goes to the table base plus 8 × index. The index is taken from virtual-address bits 47:39, 38:30, 29:21 and 20:12 for levels 0 to 3 in that order. The level-0 base is `rootBase` with bits 11:0 forced to zero, sampled at `start`.
- R3: The next table base is entry bits 47:12 followed by 12 zero bits. Entry bits 62:48 and 11:3 have no effect on any output.
- R4: An entry whose bit 0 (present) is clear ends the walk with `fault`=1, `faultCause`=0 and `faultLevel` set to that level. No further read is issued, so the walk makes exactly L+1 reads.
- R5: A walk with no fault returns `paddr` = last entry bits 47:12 concatenated with virtual-address bits 11:0, with bits 63:48 zero. Virtual-address bits 63:48 do not affect the result.
- R6: A write access faults with cause 1 unless entry bit 1 (writable) is set at all four levels.
- R7: A user-mode access faults with cause 2 unless entry bit 2 (user) is set at all four levels.
- R8: A fetch access faults with cause 3 if entry bit 63 (no-execute) is set at any level. When several permission checks fail, the cause is chosen in the order user, then write, then fetch. A permission fault reports `faultLevel`=3.
- R9: A request holds `memReqValid` and a stable `memReqAddr` until `memReqReady`. Each request must be answered by one response beat before the next request starts.
- R10: A `start` pulse during a running walk is ignored: the walk's result and its read count do not change.
- R11: `done` is high for exactly one cycle per walk. `fault`, `faultCause`, `faultLevel` and `paddr` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 64 | Virtual address to translate |
| rootBase | input | 64 | Physical base of the top-level table |
| accWrite | input | 1 | Access is a write |
| accUser | input | 1 | Access is from user mode |
| accFetch | input | 1 | Access is an instruction fetch |
| memReqValid | output | 1 | Entry read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Physical address of the entry |
| memRspValid | input | 1 | Response beat valid |
| memRspData | input | 64 | Entry contents |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Walk ended in a fault |
| faultCause | output | 2 | 0 not present, 1 write, 2 user, 3 no-execute |
| faultLevel | output | 2 | Level that caused the fault |
| paddr | output | 64 | Translated physical address |

## Verification
Fully permissive chains show that the index slicing and the base concatenation are correct. Each chain is filled with random junk in the ignored entry bits, and the same tables are also walked with altered upper virtual-address bits. A not-present entry is placed at the first, a middle and the last level, so that the read count and `faultLevel` show where the walk stopped. Single permission bits are cleared at one level at a time, and some patterns break two checks at once, which separates the combination of flags across levels from the cause priority. The memory stalls `memReqReady` at random and delays responses. A second `start` arrives partway through one walk. Randomised chains with mixed flags and access kinds are compared with a reference walk in the bench.

// File: rtl/ptwPkg.sv
package ptwPkg;
  localparam int LEVELS   = 4;
  localparam int IDX_W    = 9;
  localparam int OFF_W    = 12;
  localparam int ENT_LG   = 3;
  localparam int VA_W     = 64;
  localparam int PA_W     = 64;
  localparam int PTE_W    = 64;
  localparam int PPN_LO   = 12;
  localparam int PPN_HI   = 47;
  localparam int PPN_W    = PPN_HI - PPN_LO + 1;
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int BIT_PRES = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_USR  = 2;
  localparam int BIT_NX   = 63;

  typedef enum logic [1:0] {
    CAUSE_NOTPRESENT = 2'd0,
    CAUSE_WRITE      = 2'd1,
    CAUSE_USER       = 2'd2,
    CAUSE_EXEC       = 2'd3
  } faultCause_e;

  typedef struct packed {
    logic             capture;
    logic             accept;
    logic [LVL_W-1:0] lvl;
  } walkStrobe_t;
endpackage

// File: rtl/ptwCtrl.sv
module ptwCtrl
  import ptwPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        entryPresent,
  output logic        memReqValid,
  output logic        done,
  output walkStrobe_t strb
);
  typedef enum logic [3:0] {
    S_IDLE, S_ISS0, S_WAIT0, S_ISS1, S_WAIT1,
    S_ISS2, S_WAIT2, S_ISS3, S_WAIT3, S_DONE
  } state_e;

  state_e curState, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) curState <= S_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState    = curState;
    strb        = '0;
    memReqValid = 1'b0;
    case (curState)
      S_IDLE: if (start) begin
        strb.capture = 1'b1;
        nxtState     = S_ISS0;
      end
      S_ISS0: begin
        memReqValid = 1'b1;
        strb.lvl    = LVL_W'(0);
        if (memReqReady) nxtState = S_WAIT0;
      end
      S_WAIT0: begin
        strb.lvl = LVL_W'(0);
        if (memRspValid) begin
          strb.accept = 1'b1;
          nxtState    = entryPresent ? S_ISS1 : S_DONE;
        end
      end
      S_ISS1: begin
        memReqValid = 1'b1;
        strb.lvl    = LVL_W'(1);
        if (memReqReady) nxtState = S_WAIT1;
      end
      S_WAIT1: begin
        strb.lvl = LVL_W'(1);
        if (memRspValid) begin
          strb.accept = 1'b1;
          nxtState    = entryPresent ? S_ISS2 : S_DONE;
        end
      end
      S_ISS2: begin
        memReqValid = 1'b1;
        strb.lvl    = LVL_W'(2);
        if (memReqReady) nxtState = S_WAIT2;
      end
      S_WAIT2: begin
        strb.lvl = LVL_W'(2);
        if (memRspValid) begin
          strb.accept = 1'b1;
          nxtState    = entryPresent ? S_ISS3 : S_DONE;
        end
      end
      S_ISS3: begin
        memReqValid = 1'b1;
        strb.lvl    = LVL_W'(3);
        if (memReqReady) nxtState = S_WAIT3;
      end
      S_WAIT3: begin
        strb.lvl = LVL_W'(3);
        if (memRspValid) begin
          strb.accept = 1'b1;
          nxtState    = S_DONE;
        end
      end
      S_DONE:  nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  assign done = (curState == S_DONE);
endmodule

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptwPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PA_W-1:0]   rootBase,
  input  logic              accWrite,
  input  logic              accUser,
  input  logic              accFetch,
  input  logic [PTE_W-1:0]  memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic              entryPresent,
  output logic              fault,
  output logic [1:0]        faultCause,
  output logic [LVL_W-1:0]  faultLevel,
  output logic [PA_W-1:0]   paddr
);
  localparam int PAD_IDX = PA_W - IDX_W - ENT_LG;
  localparam int PAD_PPN = PA_W - PPN_W - OFF_W;

  logic [VA_W-1:0]  vaReg;
  logic [PA_W-1:0]  baseReg;
  logic             wrReg, usrReg, fetReg;
  logic             wAll, uAll, nxAny;
  logic [IDX_W-1:0] idxArr [LEVELS];

  genvar gl;
  generate
    for (gl = 0; gl < LEVELS; gl++) begin : g_idx
      assign idxArr[gl] = vaReg[OFF_W + IDX_W*(LEVELS-1-gl) +: IDX_W];
    end
  endgenerate

  assign memReqAddr   = baseReg + {{PAD_IDX{1'b0}}, idxArr[strb.lvl], {ENT_LG{1'b0}}};
  assign entryPresent = memRspData[BIT_PRES];

  logic [PA_W-1:0] nextBase;
  logic            wAcc, uAcc, nxAcc, permFault;
  logic [1:0]      permCause;

  assign nextBase = {{PAD_PPN{1'b0}}, memRspData[PPN_HI:PPN_LO], {OFF_W{1'b0}}};
  assign wAcc     = wAll & memRspData[BIT_WR];
  assign uAcc     = uAll & memRspData[BIT_USR];
  assign nxAcc    = nxAny | memRspData[BIT_NX];

  always_comb begin
    permFault = 1'b1;
    permCause = CAUSE_NOTPRESENT;
    if (usrReg && !uAcc)       permCause = CAUSE_USER;
    else if (wrReg && !wAcc)   permCause = CAUSE_WRITE;
    else if (fetReg && nxAcc)  permCause = CAUSE_EXEC;
    else                       permFault = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg      <= '0;
      baseReg    <= '0;
      wrReg      <= 1'b0;
      usrReg     <= 1'b0;
      fetReg     <= 1'b0;
      wAll       <= 1'b1;
      uAll       <= 1'b1;
      nxAny      <= 1'b0;
      fault      <= 1'b0;
      faultCause <= '0;
      faultLevel <= '0;
      paddr      <= '0;
    end else if (strb.capture) begin
      vaReg      <= vaddr;
      baseReg    <= {rootBase[PA_W-1:OFF_W], {OFF_W{1'b0}}};
      wrReg      <= accWrite;
      usrReg     <= accUser;
      fetReg     <= accFetch;
      wAll       <= 1'b1;
      uAll       <= 1'b1;
      nxAny      <= 1'b0;
      fault      <= 1'b0;
      faultCause <= '0;
      faultLevel <= '0;
      paddr      <= '0;
    end else if (strb.accept) begin
      if (!entryPresent) begin
        fault      <= 1'b1;
        faultCause <= CAUSE_NOTPRESENT;
        faultLevel <= strb.lvl;
      end else begin
        baseReg <= nextBase;
        wAll    <= wAcc;
        uAll    <= uAcc;
        nxAny   <= nxAcc;
        if (strb.lvl == LVL_W'(LEVELS-1)) begin
          fault      <= permFault;
          faultCause <= permCause;
          faultLevel <= LVL_W'(LEVELS-1);
          paddr      <= {{PAD_PPN{1'b0}}, memRspData[PPN_HI:PPN_LO], vaReg[OFF_W-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptwPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] vaddr,
  input  logic [63:0] rootBase,
  input  logic        accWrite,
  input  logic        accUser,
  input  logic        accFetch,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [63:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        done,
  output logic        fault,
  output logic [1:0]  faultCause,
  output logic [1:0]  faultLevel,
  output logic [63:0] paddr
);
  walkStrobe_t strb;
  logic        entryPresent;

  ptwCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .entryPresent (entryPresent),
    .memReqValid  (memReqValid),
    .done         (done),
    .strb         (strb)
  );

  ptwDatapath i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .vaddr        (vaddr),
    .rootBase     (rootBase),
    .accWrite     (accWrite),
    .accUser      (accUser),
    .accFetch     (accFetch),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .entryPresent (entryPresent),
    .fault        (fault),
    .faultCause   (faultCause),
    .faultLevel   (faultLevel),
    .paddr        (paddr)
  );
endmodule

// File: rtl/ptwChecker.sv
module ptwChecker (
  input logic        clk,
  input logic        rstN,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [63:0] memReqAddr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  faultCause,
  input logic [1:0]  faultLevel
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!memReqValid && !done));

  p_entry_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[2:0] == 3'b000));

  p_perm_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault && faultCause != 2'd0) |-> (faultLevel == 2'd3));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReqValid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind ptWalker ptwChecker i_ptwChecker (
  .clk         (clk),
  .rstN        (rstN),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .done        (done),
  .fault       (fault),
  .faultCause  (faultCause),
  .faultLevel  (faultLevel)
);

// File: tb/test_ptWalker.sv
module test_ptWalker;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0, rootBase = '0;
  logic        accWrite = 1'b0, accUser = 1'b0, accFetch = 1'b0;
  logic        memReqValid, memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done, fault;
  logic [1:0]  faultCause, faultLevel;
  logic [63:0] paddr;

  int total = 0, bad = 0;
  int reads = 0;
  int rspCnt = 0;
  logic [63:0] rspHold = '0;
  logic [63:0] firstAddr = '0;
  logic [63:0] mem [logic [63:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptWalker i_ptWalker (.*);

  // memory model: decisions at negedge, seen by the design at the next posedge
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspCnt > 0) begin
      rspCnt = rspCnt - 1;
      if (rspCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rspHold;
      end
    end
    memReqReady = ($urandom % 4) != 0;
    if (memReqValid && memReqReady && rspCnt == 0 && !memRspValid) begin
      if (reads == 0) firstAddr = memReqAddr;
      reads   = reads + 1;
      rspHold = mem.exists(memReqAddr) ? mem[memReqAddr] : 64'd0;
      rspCnt  = 1 + int'($urandom % 3);
    end else if (memRspValid || rspCnt != 0) begin
      memReqReady = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] rndBase();
    return {24'd0, 28'($urandom), 12'd0};
  endfunction

  // fill a chain for va; masks bit L controls level L
  task automatic buildChain(input logic [63:0] va, input logic [63:0] root,
                            input logic [3:0] pM, input logic [3:0] wM,
                            input logic [3:0] uM, input logic [3:0] nxM);
    logic [63:0] base = root;
    for (int l = 0; l < 4; l++) begin
      logic [63:0] nb = rndBase();
      logic [63:0] e  = rnd64();
      logic [8:0]  ix = 9'((va >> (39 - 9*l)) & 64'h1ff);
      e[63]    = nxM[l];
      e[47:12] = nb[47:12];
      e[2]     = uM[l];
      e[1]     = wM[l];
      e[0]     = pM[l];
      mem[base + {52'd0, ix, 3'd0}] = e;
      base = nb;
    end
  endtask

  task automatic refWalk(input logic [63:0] va, input logic [63:0] root,
                         input bit w, input bit u, input bit f,
                         output bit eF, output logic [1:0] eC, output logic [1:0] eL,
                         output logic [63:0] eP, output int eR, output logic [63:0] eFirst);
    logic [63:0] base = {root[63:12], 12'd0};
    logic [63:0] e = '0;
    bit wa = 1, ua = 1, nx = 0;
    eF = 0; eC = 0; eL = 0; eP = 0; eR = 0;
    eFirst = base + {52'd0, 9'((va >> 39) & 64'h1ff), 3'd0};
    for (int l = 0; l < 4; l++) begin
      logic [63:0] a = base + {52'd0, 9'((va >> (39 - 9*l)) & 64'h1ff), 3'd0};
      eR++;
      e = mem.exists(a) ? mem[a] : 64'd0;
      if (!e[0]) begin
        eF = 1; eC = 2'd0; eL = 2'(l);
        return;
      end
      wa &= e[1]; ua &= e[2]; nx |= e[63];
      base = {16'd0, e[47:12], 12'd0};
    end
    eL = 2'd3;
    if (u && !ua)      begin eF = 1; eC = 2'd2; end
    else if (w && !wa) begin eF = 1; eC = 2'd1; end
    else if (f && nx)  begin eF = 1; eC = 2'd3; end
    if (!eF) eP = {16'd0, e[47:12], va[11:0]};
  endtask

  function automatic string causeTag(input logic [1:0] c);
    case (c)
      2'd0: return "R4";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic runWalk(input logic [63:0] va, input logic [63:0] root,
                         input bit w, input bit u, input bit f,
                         input bit interfere, input string name);
    bit eF; logic [1:0] eC, eL; logic [63:0] eP, eFirst; int eR;
    int waitCnt = 0;
    logic [63:0] heldPaddr;
    refWalk(va, root, w, u, f, eF, eC, eL, eP, eR, eFirst);
    @(negedge clk);
    reads = 0;
    vaddr = va; rootBase = root; accWrite = w; accUser = u; accFetch = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (interfere) begin
      @(negedge clk); @(negedge clk);
      vaddr = ~va; rootBase = rndBase(); accWrite = 1; accUser = 1; accFetch = 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk({"R11 done seen ", name}, 64'(done), 64'd1);
    chk({"R2 first entry address ", name}, firstAddr, eFirst);
    chk({interfere ? "R10 " : "", "R4 R9 read count ", name}, 64'(reads), 64'(eR));
    chk({interfere ? "R10 " : "", causeTag(eC), " fault ", name}, 64'(fault), 64'(eF));
    if (eF) begin
      chk({causeTag(eC), " cause ", name}, 64'(faultCause), 64'(eC));
      chk({(eC == 0) ? "R4" : "R8", " level ", name}, 64'(faultLevel), 64'(eL));
    end else begin
      chk({interfere ? "R10 " : "", "R3 R5 paddr ", name}, paddr, eP);
    end
    heldPaddr = paddr;
    @(negedge clk);
    chk({"R11 done pulse ", name}, 64'(done), 64'd0);
    chk({"R11 result held ", name}, paddr, heldPaddr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] va, root;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset req", 64'(memReqValid), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset req", 64'(memReqValid), 64'd0);
    chk("R1 after reset done", 64'(done), 64'd0);

    // directed corners
    va = rnd64(); root = rndBase();
    mem.delete(); buildChain(va, root, 4'hf, 4'hf, 4'hf, 4'h0);
    runWalk(va, root, 0, 0, 0, 0, "plain");
    runWalk(va, root, 1, 1, 1, 0, "all access kinds allowed");
    runWalk({16'habcd, va[47:0]}, root, 0, 0, 0, 0, "R5 upper bits ignored");
    runWalk(va, root, 0, 0, 0, 1, "R10 restart ignored");

    mem.delete(); buildChain(va, root, 4'b1110, 4'hf, 4'hf, 4'h0);
    runWalk(va, root, 0, 0, 0, 0, "absent top");
    mem.delete(); buildChain(va, root, 4'b1011, 4'hf, 4'hf, 4'h0);
    runWalk(va, root, 1, 1, 1, 0, "absent level2");
    mem.delete(); buildChain(va, root, 4'b0111, 4'hf, 4'hf, 4'h0);
    runWalk(va, root, 0, 0, 0, 0, "absent last");

    mem.delete(); buildChain(va, root, 4'hf, 4'b1101, 4'hf, 4'h0);
    runWalk(va, root, 1, 0, 0, 0, "R6 write denied");
    runWalk(va, root, 0, 0, 0, 0, "R6 read allowed");
    mem.delete(); buildChain(va, root, 4'hf, 4'hf, 4'b0111, 4'h0);
    runWalk(va, root, 0, 1, 0, 0, "R7 user denied");
    mem.delete(); buildChain(va, root, 4'hf, 4'b1011, 4'b1110, 4'b0001);
    runWalk(va, root, 1, 1, 1, 0, "R8 priority user");
    runWalk(va, root, 1, 0, 1, 0, "R8 priority write");
    runWalk(va, root, 0, 0, 1, 0, "R8 exec denied");
    runWalk(va, root, 0, 0, 0, 0, "R8 data read ok");

    // randomised
    for (int n = 0; n < 60; n++) begin
      logic [3:0] pM, wM, uM, nxM;
      va = rnd64(); root = rndBase() | 64'($urandom % 4096);
      pM  = 4'hf; wM = 4'hf; uM = 4'hf; nxM = 4'h0;
      for (int l = 0; l < 4; l++) begin
        pM[l]  = ($urandom % 12) != 0;
        wM[l]  = ($urandom % 4) != 0;
        uM[l]  = ($urandom % 4) != 0;
        nxM[l] = ($urandom % 8) == 0;
      end
      mem.delete();
      buildChain({root[63:12], 12'd0} == 0 ? va : va, {root[63:12], 12'd0}, pM, wM, uM, nxM);
      runWalk(va, root, 1'($urandom), 1'($urandom), 1'($urandom), 0, "random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule